// File: doc/BRIEF.md
# Serially Programmed Preset-Reload Frequency Divider

This block divides its clock by a modulus that is loaded over a three-wire serial link. A 12-bit up-counter is preset to a loaded value and runs to all-ones. On the cycle after it sits at all-ones it emits a one-clock output pulse and is reloaded. In programmed mode the reload value is the latched word L, which gives a period of 2^12 − L clocks. Outside programmed mode, and after reset, the reload value is zero and the counter runs its full 4096-state range.

The word is shifted in MSB first on rising edges of a slow data clock. A rising edge of a separate load strobe copies the shift register into a holding latch and presets the counter to that value in the same cycle. The data clock, the data bit and the strobe are each brought into the divider clock domain through a two-stage synchronizer. A latched word outside the intended window 3300..3830 is still used as written, but raises a flag.

A two-state controller tracks the mode. FREE uses zero as the reload value. PROG uses the latched value. The transition FREE→PROG is taken when `prog_mode` is high, and PROG→FREE is taken when it is low. The state register follows `prog_mode` with one clock of delay and affects only the next reload.

Top module: `preset_divider`

## Requirements
- R1: After synchronous reset, `div_pulse` and `range_err` are 0, the counter, shift register and latch are 0, and the controller is in FREE.
- R2: On each synchronized rising edge of `ser_clk`, the shift register moves one bit toward its MSB and takes the synchronized `ser_data` into bit 0, so the first bit sent becomes bit 11 (MSB first).
- R3: On a synchronized rising edge of `load_strobe`, the holding latch and the counter both take the shift-register value on the same clock. The strobe takes priority over any reload in that cycle.
- R4: When not preset, the counter advances by one per clock. While it is at all-ones, `div_pulse` is 1 on the following cycle. Each pulse is exactly one clock wide whenever the reload value is not all-ones.
- R5: In PROG, the counter reloads from the latch, so the period is 4096 − L clocks (796 for L=3300, 266 for L=3830).
- R6: In FREE, the counter reloads to 0, so the period is 4096 clocks.
- R7: Going back to PROG without a new strobe reuses the value last latched.
- R8: At each strobe, `range_err` becomes 1 if the loaded value is below 3300 or above 3830, and 0 otherwise. An out-of-range value still sets the period. `range_err` changes at no other time.
- R9: A change of `prog_mode` does not disturb a count in progress. It only selects the value used at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divider input clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_data | input | 1 | Serial modulus data, MSB first |
| ser_clk | input | 1 | Serial data clock, shifts on rising edge |
| load_strobe | input | 1 | Rising edge latches the word and presets the counter |
| prog_mode | input | 1 | 1 = programmed modulus, 0 = full-range count |
| div_pulse | output | 1 | One-clock pulse per counter cycle |
| range_err | output | 1 | Last latched word lies outside 3300..3830 |

## Verification
The bench builds the block with its default parameters: a 12-bit counter, a window of 3300..3830, and two synchronizer stages. This makes the real 4096-clock free period reachable, as well as both window edges (266 and 796 clocks) and an out-of-range load of 100 (3996 clocks). A behavioural integer model runs alongside and is compared on every clock. Mode changes in the middle of a cycle, and a return to programmed mode without a new strobe, are also exercised.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;
    typedef enum logic [0:0] {
        ST_FREE = 1'b0,
        ST_PROG = 1'b1
    } pdiv_state_e;
endpackage

// File: rtl/pdiv_sync.sv
module pdiv_sync #(
    parameter int STAGES = 2,
    parameter bit EDGE   = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], din};
    end

    generate
        if (EDGE) begin : g_edge
            logic prev;
            always_ff @(posedge clk) begin
                if (rst) prev <= 1'b0;
                else     prev <= sh[STAGES-1];
            end
            assign q = sh[STAGES-1] & ~prev;
        end else begin : g_level
            assign q = sh[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/pdiv_shifter.sv
module pdiv_shifter #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)           q <= '0;
        else if (shift_en) q <= {q[W-2:0], din};
    end

    assert_shift_msb_first_R2: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> q == {$past(q[W-2:0]), $past(din)});
    assert_shift_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(q));
endmodule

// File: rtl/pdiv_core.sv
module pdiv_core
    import pdiv_pkg::*;
#(
    parameter int W      = 12,
    parameter int WIN_LO = 3300,
    parameter int WIN_HI = 3830
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         prog_mode,
    input  logic         strobe,
    input  logic [W-1:0] preset_val,
    output logic         pulse,
    output logic         range_err
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
    localparam logic [W-1:0] LO_V     = W'(WIN_LO);
    localparam logic [W-1:0] HI_V     = W'(WIN_HI);

    pdiv_state_e  state_q, state_d;
    logic [W-1:0] cnt_q, latch_q, reload_val;
    logic         carry;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FREE: if (prog_mode)  state_d = ST_PROG;
            ST_PROG: if (!prog_mode) state_d = ST_FREE;
            default: state_d = ST_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FREE;
        else     state_q <= state_d;
    end

    assign carry      = (cnt_q == ALL_ONES);
    assign reload_val = (state_q == ST_PROG) ? latch_q : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            latch_q   <= '0;
            pulse     <= 1'b0;
            range_err <= 1'b0;
        end else begin
            pulse <= carry;
            if (strobe) begin
                latch_q   <= preset_val;
                cnt_q     <= preset_val;
                range_err <= (preset_val < LO_V) || (preset_val > HI_V);
            end else if (carry) begin
                cnt_q <= reload_val;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assert_preset_R3: assert property (@(posedge clk) disable iff (rst)
        strobe |=> (cnt_q == $past(preset_val)) && (latch_q == $past(preset_val)));
    assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
        (!strobe && cnt_q != ALL_ONES) |=> cnt_q == $past(cnt_q) + 1'b1);
    assert_carry_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == ALL_ONES) |=> pulse);
    assert_pulse_width_R4: assert property (@(posedge clk) disable iff (rst)
        (pulse && cnt_q != ALL_ONES) |=> !pulse);
    assert_prog_reload_R5: assert property (@(posedge clk) disable iff (rst)
        (carry && !strobe && state_q == ST_PROG) |=> cnt_q == $past(latch_q));
    assert_free_reload_R6: assert property (@(posedge clk) disable iff (rst)
        (carry && !strobe && state_q == ST_FREE) |=> cnt_q == '0);
    assert_flag_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(range_err));
endmodule

// File: rtl/preset_divider.sv
module preset_divider #(
    parameter int CNT_W       = 12,
    parameter int WIN_LO      = 3300,
    parameter int WIN_HI      = 3830,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ser_data,
    input  logic ser_clk,
    input  logic load_strobe,
    input  logic prog_mode,
    output logic div_pulse,
    output logic range_err
);
    logic             shift_rise, data_s, strobe_rise;
    logic [CNT_W-1:0] shift_q;

    pdiv_sync #(.STAGES(SYNC_STAGES), .EDGE(1'b1)) u_sclk (
        .clk(clk), .rst(rst), .din(ser_clk), .q(shift_rise));
    pdiv_sync #(.STAGES(SYNC_STAGES), .EDGE(1'b0)) u_sdat (
        .clk(clk), .rst(rst), .din(ser_data), .q(data_s));
    pdiv_sync #(.STAGES(SYNC_STAGES), .EDGE(1'b1)) u_strb (
        .clk(clk), .rst(rst), .din(load_strobe), .q(strobe_rise));

    pdiv_shifter #(.W(CNT_W)) u_shift (
        .clk(clk), .rst(rst), .shift_en(shift_rise), .din(data_s), .q(shift_q));

    pdiv_core #(.W(CNT_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_core (
        .clk(clk), .rst(rst), .prog_mode(prog_mode), .strobe(strobe_rise),
        .preset_val(shift_q), .pulse(div_pulse), .range_err(range_err));

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> !div_pulse && !range_err);
endmodule

// File: tb/preset_divider_test.sv
module preset_divider_test;
    localparam int CLK_PERIOD = 10;
    localparam int FULL       = 4096;

    logic clk = 1'b0, rst = 1'b1;
    logic ser_data = 1'b0, ser_clk = 1'b0, load_strobe = 1'b0, prog_mode = 1'b0;
    logic div_pulse, range_err;

    int total = 0, bad = 0, cyc = 0;

    preset_divider uut (
        .clk(clk), .rst(rst), .ser_data(ser_data), .ser_clk(ser_clk),
        .load_strobe(load_strobe), .prog_mode(prog_mode),
        .div_pulse(div_pulse), .range_err(range_err));

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    bit qc[$] = '{0, 0, 0};
    bit qd[$] = '{0, 0, 0};
    bit qs[$] = '{0, 0, 0};
    int m_cnt = 0, m_latch = 0, m_sreg = 0;
    bit m_prog = 0, m_pulse = 0, m_err = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_latch = 0; m_sreg = 0;
            m_prog = 0; m_pulse = 0; m_err = 0;
            qc = '{0, 0, 0}; qd = '{0, 0, 0}; qs = '{0, 0, 0};
        end else begin
            bit c_rise, s_rise, d, carry;
            int old_sreg;
            c_rise = qc[1] && !qc[0];
            s_rise = qs[1] && !qs[0];
            d = qd[1];
            carry = (m_cnt == FULL - 1);
            old_sreg = m_sreg;
            m_pulse = carry;
            if (s_rise) begin
                m_latch = old_sreg;
                m_cnt = old_sreg;
                m_err = (old_sreg < 3300) || (old_sreg > 3830);
            end else if (carry) begin
                m_cnt = m_prog ? m_latch : 0;
            end else begin
                m_cnt = m_cnt + 1;
            end
            if (c_rise) m_sreg = ((old_sreg << 1) | int'(d)) % FULL;
            m_prog = prog_mode;
            void'(qc.pop_front()); qc.push_back(ser_clk);
            void'(qd.pop_front()); qd.push_back(ser_data);
            void'(qs.pop_front()); qs.push_back(load_strobe);
        end
    end

    task automatic check(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            check(div_pulse == m_pulse, "R4/R5/R6/R9 pulse vs model", div_pulse, m_pulse);
            check(range_err == m_err, "R8 flag vs model", range_err, m_err);
        end
        if (cyc > 190000) begin
            check(0, "watchdog", cyc, 190000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic send_word(int v);
        for (int i = 11; i >= 0; i--) begin
            @(negedge clk); ser_data = v[i];
            repeat (4) @(negedge clk); ser_clk = 1'b1;
            repeat (4) @(negedge clk); ser_clk = 1'b0;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic strobe();
        @(negedge clk); load_strobe = 1'b1;
        repeat (4) @(negedge clk); load_strobe = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_pulse();
        int n = 0;
        do begin @(negedge clk); n++; end while (!div_pulse && n < 10000);
    endtask

    task automatic measure(int exp, string tag);
        int n = 0;
        wait_pulse();
        do begin @(negedge clk); n++; end while (!div_pulse && n < 10000);
        check(n == exp, tag, n, exp);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check(div_pulse == 1'b0, "R1 pulse after reset", div_pulse, 0);
        check(range_err == 1'b0, "R1 flag after reset", range_err, 0);
        rst = 1'b0;
        @(negedge clk);
        check(div_pulse == 1'b0, "R1 pulse first cycle", div_pulse, 0);
        measure(4096, "R6 free-running period");

        prog_mode = 1'b1;
        send_word(3300); strobe();
        measure(796, "R5 period at L=3300");
        check(range_err == 1'b0, "R8 flag low for 3300", range_err, 0);

        send_word(3830); strobe();
        measure(266, "R5 period at L=3830");
        check(range_err == 1'b0, "R8 flag low for 3830", range_err, 0);
        @(negedge clk);
        check(div_pulse == 1'b0, "R4 pulse one clock wide", div_pulse, 0);

        send_word(100); strobe();
        check(range_err == 1'b1, "R8 flag high for 100", range_err, 1);
        measure(3996, "R8 out-of-range value still used");

        send_word(3500); strobe();
        check(range_err == 1'b0, "R8 flag cleared for 3500", range_err, 0);
        measure(596, "R2 MSB-first word 3500 gives 596");

        send_word(3299); strobe();
        check(range_err == 1'b1, "R8 flag high for 3299", range_err, 1);
        send_word(3831); strobe();
        check(range_err == 1'b1, "R8 flag high for 3831", range_err, 1);
        send_word(3500); strobe();
        measure(596, "R3 new strobe sets period");

        repeat (100) @(negedge clk);
        prog_mode = 1'b0;
        wait_pulse();
        measure(4096, "R6 back to full range");

        repeat (1000) @(negedge clk);
        prog_mode = 1'b1;
        wait_pulse();
        measure(596, "R7 reuse of last latched value");
        check(range_err == 1'b0, "R7 flag unchanged", range_err, 0);

        repeat (20) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule